// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM that has an 18-bit address, a 4-bit bidirectional data bus and three active-low strobes (chip select, output enable, write enable). The host presents one request at a time through a valid/ready handshake. Each request carries an address, a write flag and write data. The controller turns the request into a strobe sequence whose phase lengths are clock counts. These counts are derived at elaboration from nanosecond timing parameters by rounding up against the clock period.

A read selects the chip and enables its outputs while write enable stays high. The controller holds this state for the longest of the read-cycle, address-access, select-access and output-enable-access times, then captures the returned data and flags it with a one-clock pulse. A write keeps the chip selected and output enable high. The controller drives the data bus, pulses write enable low for the longest of the pulse-width, address-to-end and data-setup times, then spends a recovery phase with write enable high until the full write cycle has elapsed. Between operations the chip is always deselected (standby), and the data drive is released at least one clock before output enable can fall again.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and right after it, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 1, rsp_valid is 0, and mem_addr and mem_dq_out are 0.
- R2: req_ready is 1 only when the controller is idle. A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 for the whole operation: 2 cycles for a read and 3 cycles for a write at the default parameters (100 MHz period, fastest timing grade).
- R3: A read holds mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for exactly RD_CYC cycles (2 by default), starting the cycle after acceptance. RD_CYC is the largest rounded-up count of the read-cycle, address-access, select-access and output-enable-access times.
- R4: The controller captures read data on the clock edge that ends the last read cycle. In the next cycle, rsp_valid is 1 for exactly one clock and rsp_rdata holds the captured value.
- R5: A write begins the cycle after acceptance with WP_CYC cycles (2 by default) of mem_ce_n=0, mem_we_n=0, mem_oe_n=1 and mem_dq_oe=1, with mem_dq_out equal to the accepted write data. WP_CYC is the largest rounded-up count of the write-pulse, address-to-end-of-write and data-setup times.
- R6: After write enable rises, the controller keeps mem_ce_n=0, mem_oe_n=1 and mem_dq_oe=1 with the same data for REC_CYC cycles (1 by default). This makes the whole write last at least the write-cycle time and at least one cycle longer than the pulse.
- R7: mem_dq_oe is never 1 while mem_oe_n is 0, and mem_dq_oe is 0 in the cycle before any falling edge of mem_oe_n.
- R8: mem_addr changes only on the edge that accepts a request. It is constant for every cycle with mem_ce_n=0.
- R9: Whenever no operation is in progress, mem_ce_n=1, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0.
- R10: req_valid and the request fields have no effect while req_ready is 0. No extra operation starts and the address, data and strobes keep following the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-clock pulse marking read data |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | RAM address bus |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DATA_W | Data the controller drives toward the RAM |
| mem_dq_oe | output | 1 | Enable for the controller's data drive |
| mem_dq_in | input | DATA_W | Data bus as seen from the RAM |

## Verification
Every strobe and bus output is registered, so the first strobe cycle of an operation appears one clock after the accepting edge. rsp_valid appears RD_CYC+1 clocks after that edge, and req_ready returns in the same cycle. A write's recovery phase starts WP_CYC+1 clocks after acceptance, and the controller is idle again WP_CYC+REC_CYC+1 clocks after it. The bench steps a behavioural model once per clock using the inputs sampled at the edge just passed. It compares every output at the falling edge, so each result is checked in exactly the cycle it is due. The bench's RAM model returns corrupted data until output enable has been held for RD_CYC cycles, so a capture that comes too early is detected.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_WLOW  = 2'd2,
      PH_WHOLD = 2'd3
   } phase_e;

   // nanoseconds to whole clock cycles, rounded up
   function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned per_ns);
      return (t_ns + per_ns - 1) / per_ns;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
   import sram_ctl_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e ph_next,
   output logic   ce_n,
   output logic   oe_n,
   output logic   we_n,
   output logic   dq_oe
);

   logic ce_n_d, oe_n_d, we_n_d, dq_oe_d;

   always_comb begin
      ce_n_d  = 1'b1;
      oe_n_d  = 1'b1;
      we_n_d  = 1'b1;
      dq_oe_d = 1'b0;
      unique case (ph_next)
         PH_READ: begin
            ce_n_d = 1'b0;
            oe_n_d = 1'b0;
         end
         PH_WLOW: begin
            ce_n_d  = 1'b0;
            we_n_d  = 1'b0;
            dq_oe_d = 1'b1;
         end
         PH_WHOLD: begin
            ce_n_d  = 1'b0;
            dq_oe_d = 1'b1;
         end
         default: ;
      endcase
   end

   // registered so the pins never see decode glitches
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         ce_n  <= ce_n_d;
         oe_n  <= oe_n_d;
         we_n  <= we_n_d;
         dq_oe <= dq_oe_d;
      end
   end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 18,
   parameter int unsigned DATA_W   = 4,
   parameter int unsigned CLK_NS   = 10,
   parameter int unsigned T_RC_NS  = 20,
   parameter int unsigned T_AA_NS  = 20,
   parameter int unsigned T_ACE_NS = 20,
   parameter int unsigned T_AOE_NS = 8,
   parameter int unsigned T_WC_NS  = 20,
   parameter int unsigned T_WP_NS  = 15,
   parameter int unsigned T_AW_NS  = 15,
   parameter int unsigned T_DS_NS  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned RD_RAW  = umax(umax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                          umax(ns_to_cyc(T_ACE_NS, CLK_NS), ns_to_cyc(T_AOE_NS, CLK_NS)));
   localparam int unsigned RD_CYC  = umax(RD_RAW, 1);
   localparam int unsigned WP_RAW  = umax(umax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                          ns_to_cyc(T_DS_NS, CLK_NS));
   localparam int unsigned WP_CYC  = umax(WP_RAW, 1);
   localparam int unsigned WC_RAW  = ns_to_cyc(T_WC_NS, CLK_NS);
   localparam int unsigned REC_CYC = (WC_RAW > WP_CYC + 1) ? (WC_RAW - WP_CYC) : 1;
   localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WP_CYC), REC_CYC);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   // elaboration checks
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("sram_strobe_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("sram_strobe_ctrl: DATA_W must be positive");
   end
   if (CLK_NS == 0) begin : g_bad_clk
      $error("sram_strobe_ctrl: CLK_NS must be positive");
   end

   phase_e           ph_q, ph_d;
   logic             tmr_load, tmr_done, accept;
   logic [CNT_W-1:0] tmr_val;

   assign req_ready = (ph_q == PH_IDLE);
   assign accept    = req_valid && req_ready;

   always_comb begin
      ph_d     = ph_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (ph_q)
         PH_IDLE: if (accept) begin
            tmr_load = 1'b1;
            if (req_write) begin
               ph_d    = PH_WLOW;
               tmr_val = CNT_W'(WP_CYC - 1);
            end else begin
               ph_d    = PH_READ;
               tmr_val = CNT_W'(RD_CYC - 1);
            end
         end
         PH_READ: if (tmr_done) ph_d = PH_IDLE;
         PH_WLOW: if (tmr_done) begin
            ph_d     = PH_WHOLD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(REC_CYC - 1);
         end
         PH_WHOLD: if (tmr_done) ph_d = PH_IDLE;
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         mem_addr   <= '0;
         mem_dq_out <= '0;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
      end else begin
         ph_q      <= ph_d;
         rsp_valid <= 1'b0;
         if (accept) begin
            mem_addr <= req_addr;
            if (req_write) mem_dq_out <= req_wdata;
         end
         if (ph_q == PH_READ && tmr_done) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_dq_in;
         end
      end
   end

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   sram_strobe_gen u_strobes (
      .clk     (clk),
      .rst_n   (rst_n),
      .ph_next (ph_d),
      .ce_n    (mem_ce_n),
      .oe_n    (mem_oe_n),
      .we_n    (mem_we_n),
      .dq_oe   (mem_dq_oe)
   );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
   parameter int unsigned ADDR_W  = 18,
   parameter int unsigned DATA_W  = 4,
   parameter int unsigned RD_CYC  = 2,
   parameter int unsigned WP_CYC  = 2,
   parameter int unsigned REC_CYC = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe,
   input logic [DATA_W-1:0] mem_dq_in
);

   int unsigned we_run, oe_run, hold_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run   <= 0;
         oe_run   <= 0;
         hold_run <= 0;
      end else begin
         we_run   <= (!mem_we_n) ? we_run + 1 : 0;
         oe_run   <= (!mem_oe_n) ? oe_run + 1 : 0;
         hold_run <= (!mem_ce_n && mem_we_n && mem_dq_oe) ? hold_run + 1 : 0;
      end
   end

   p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_ready_means_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && !mem_dq_oe));

   p_read_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_run == RD_CYC));

   p_read_we_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_ce_n));

   p_rsp_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_rsp_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!mem_oe_n));

   p_write_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run == WP_CYC));

   p_write_pulse_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe));

   p_write_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_ce_n) && $past(mem_dq_oe)) |-> (hold_run == REC_CYC));

   p_no_drive_into_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n));

   p_turnaround_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> !$past(mem_dq_oe));

   p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

   p_standby_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .RD_CYC  (RD_CYC),
   .WP_CYC  (WP_CYC),
   .REC_CYC (REC_CYC)
) u_chk (.*);

// File: tb/sram_strobe_ctrl_tb_top.sv
module sram_strobe_ctrl_tb_top;

   localparam int AW    = 18;
   localparam int DW    = 4;
   localparam int RD_N  = 2;   // R3 default read length
   localparam int WP_N  = 2;   // R5 default pulse length
   localparam int REC_N = 1;   // R6 default recovery length

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_ready, req_write;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out, mem_dq_in;

   always #10 clk = ~clk;

   sram_strobe_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // RAM model: returns corrupted data until output enable has been held RD_N cycles
   logic [DW-1:0] ram [64];
   logic [DW-1:0] sb  [64];
   int            rd_hold;
   logic [DW-1:0] wlatch;
   logic          we_prev;

   assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n && rd_hold >= RD_N)
                      ? ram[mem_addr[5:0]] : ~ram[mem_addr[5:0]];

   int vec = 0;
   int bad = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model state
   bit            m_busy, m_wr, e_rv;
   int            m_t;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_data, e_rd;
   int unsigned   lfsr;
   string         ptag;

   initial begin
      #(20 * 200000);
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         ram[i] = DW'(i * 7 + 3);
         sb[i]  = DW'(i * 7 + 3);
      end
      rd_hold = 0; wlatch = '0; we_prev = 1'b1;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      lfsr = 32'h1234_5679;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe} == 4'b1110, "R1 strobes in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
      chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 handshake in reset",
          {req_ready, rsp_valid}, 2'b10);
      chk(mem_addr == '0 && mem_dq_out == '0, "R1 buses in reset",
          {mem_addr, mem_dq_out}, '0);
      rst_n = 1'b1;
      m_busy = 0; m_wr = 0; m_t = 0; m_addr = '0; m_data = '0; e_rv = 0; e_rd = '0;

      for (int cyc = 0; cyc < 6000; cyc++) begin
         @(negedge clk);
         // advance model by the edge just passed
         e_rv = 0;
         if (m_busy) begin
            m_t++;
            if (m_t > (m_wr ? WP_N + REC_N : RD_N)) begin
               m_busy = 0;
               if (!m_wr) begin
                  e_rv = 1;
                  e_rd = sb[m_addr[5:0]];
               end
            end
         end else if (req_valid) begin
            m_busy = 1; m_t = 1; m_wr = req_write;
            m_addr = req_addr; m_data = req_wdata;
            if (req_write) sb[req_addr[5:0]] = req_wdata;
         end

         ptag = !m_busy ? "R9 standby" : !m_wr ? "R3 read strobes" :
                (m_t <= WP_N) ? "R5 write pulse" : "R6 write recovery";

         chk(req_ready == !m_busy, "R2/R10 ready", req_ready, !m_busy);
         chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe} ==
             {!m_busy, !(m_busy && !m_wr), !(m_busy && m_wr && m_t <= WP_N), (m_busy && m_wr)},
             ptag, {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe},
             {!m_busy, !(m_busy && !m_wr), !(m_busy && m_wr && m_t <= WP_N), (m_busy && m_wr)});
         chk(!(mem_dq_oe && !mem_oe_n), "R7 drive while output enabled",
             {mem_dq_oe, mem_oe_n}, 2'b01);
         chk(mem_addr == m_addr, "R8/R10 address", mem_addr, m_addr);
         if (mem_dq_oe)
            chk(mem_dq_out == m_data, "R5 write data", mem_dq_out, m_data);
         chk(rsp_valid == e_rv, "R4 read valid pulse", rsp_valid, e_rv);
         if (e_rv)
            chk(rsp_rdata == e_rd, "R4 read data", rsp_rdata, e_rd);

         // RAM model bookkeeping
         if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_hold++; else rd_hold = 0;
         if (!mem_ce_n && !mem_we_n && mem_dq_oe) wlatch = mem_dq_out;
         if (!we_prev && mem_we_n) ram[mem_addr[5:0]] = wlatch;
         we_prev = mem_we_n;

         // next stimulus
         lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
         if (!m_busy) begin
            req_valid = (lfsr[7:6] != 2'b00) || (cyc < 40);
            req_write = (cyc < 40) ? cyc[2] : lfsr[8];
            req_addr  = {AW'(lfsr[31:20]) << 6} | AW'(lfsr[2:0]);
            req_wdata = DW'(lfsr[15:12]);
         end else begin
            // R10 junk while busy
            req_valid = lfsr[3];
            req_write = lfsr[9];
            req_addr  = AW'(lfsr[27:10]);
            req_wdata = DW'(lfsr[19:16]);
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

endmodule